// File: doc/BRIEF.md
# Pulse-Length Modulated Slot Transmitter

This block turns a stream of payload bits into a single-wire signal. Every pulse on the wire starts a fixed number of clock cycles after the previous one, so a phase-locked loop on the far end can track the leading edges. The data is carried by where each pulse ends. A one is sent as a long pulse and a zero as a short pulse. Three runtime inputs set the timing, all counted in clock cycles: the pulse period, the low time that follows a long pulse, and the low time that follows a short pulse. A low time of about a quarter of the period after a long pulse and about three quarters after a short pulse is a sensible choice.

An optional group mode sends each payload bit as eight pulses. The group opens with a fixed long pulse and then a fixed short pulse, which a receiver can use to find where the group starts. The remaining six pulses repeat the bit, alternating between its inverse and its true value. The receiver sums these six pulses, so the difference between long and short pulses can be kept small, and the loop downstream sees little jitter.

Bits arrive from an upstream framer over a valid/ready handshake. A one-cycle marker flags the first pulse of each bit, or of each group in group mode. If the framer has no bit ready when one is needed, the block sends a zero and flags an underrun.

Top module: `plm_slot_tx`

## Requirements
- R1: Successive rising edges of `line_o` are exactly `period_i` cycles apart. This holds for every pulse, whatever the data. The configuration is valid when 1 <= each low time < period.
- R2: A pulse that encodes a one stays high for `period_i - low_long_i` cycles.
- R3: A pulse that encodes a zero stays high for `period_i - low_short_i` cycles.
- R4: With `group_mode_i` = 1, a payload bit q is sent as eight pulses with the levels 1, 0, ~q, q, ~q, q, ~q, q, in that order. Level 1 is a long pulse and level 0 is a short pulse.
- R5: `bit_ready_o` is high only in the last cycle of a bit's final pulse, and in the first cycle after reset. A bit accepted at that clock edge makes `line_o` rise in the very next cycle.
- R6: If `bit_valid_i` is low when a bit is due, a zero is sent instead. In that case `underrun_o` is high for one cycle, in the same cycle as `group_start_o`.
- R7: The period and both low times are sampled only where one pulse ends and the next begins. A change made in the middle of a pulse leaves that pulse unchanged and takes effect from the next pulse.
- R8: `group_mode_i` is sampled only when a new payload bit starts. A change in the middle of a group does not shorten or reshape the group.
- R9: `group_start_o` is high for exactly one cycle: the cycle in which `line_o` rises at the start of each bit's first pulse.
- R10: While reset is held, `line_o`, `group_start_o` and `underrun_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | PERIOD_W | Cycles from one rising edge to the next |
| low_long_i | input | PERIOD_W | Low cycles after a long (one) pulse |
| low_short_i | input | PERIOD_W | Low cycles after a short (zero) pulse |
| group_mode_i | input | 1 | 1 selects the eight-pulse group per bit |
| bit_valid_i | input | 1 | Upstream has a payload bit |
| bit_data_i | input | 1 | Payload bit value |
| bit_ready_o | output | 1 | Block takes the bit at this clock edge |
| line_o | output | 1 | Serial pulse output (registered) |
| group_start_o | output | 1 | First pulse of a bit or group is rising |
| underrun_o | output | 1 | The bit now starting was filled with zero |

## Verification
Every output is registered. A bit accepted at an edge shows up one cycle later as a rising `line_o` together with `group_start_o`, and `underrun_o` is raised in that same cycle when the bit was filled in. The high time and period of a pulse are only known once the next rising edge appears. The bench therefore measures each pulse at the following rising edge, in cycles between falling clock edges. It compares that measurement with a queue of expected pulses, filled at the moment of acceptance from the configuration driven then. The rise cycle is also compared with the acceptance cycle plus one. Inputs change one nanosecond after a falling edge, so each sample falls clearly between the clock edges where the design registers values.

// File: rtl/plm_pkg.sv
package plm_pkg;
   localparam int unsigned GROUP_LEN = 8;
   localparam int unsigned SLOT_W    = $clog2(GROUP_LEN);

   typedef logic [SLOT_W-1:0] slot_t;

   // Level of slot idx inside an eight-pulse group carrying bit q:
   // two framing slots (long, short), then inverse/true alternating.
   function automatic logic slot_level(input slot_t idx, input logic q);
      if (idx == slot_t'(0)) return 1'b1;
      if (idx == slot_t'(1)) return 1'b0;
      return idx[0] ? q : ~q;
   endfunction
endpackage

// File: rtl/plm_pulse_timer.sv
module plm_pulse_timer #(
   parameter int unsigned PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] period_i,
   input  logic [PW-1:0] low_long_i,
   input  logic [PW-1:0] low_short_i,
   input  logic          level_i,
   output logic          pulse_end_o,
   output logic          line_o
);
   logic [PW-1:0] cnt_q;
   logic [PW-1:0] per_q;
   logic [PW-1:0] hi_q;
   logic [PW-1:0] cnt_inc;
   logic [PW-1:0] hi_n;
   logic          first_q;
   logic          line_q;

   assign cnt_inc     = cnt_q + 1'b1;
   assign pulse_end_o = first_q | (cnt_inc == per_q);
   assign hi_n        = period_i - (level_i ? low_long_i : low_short_i);
   assign line_o      = line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         per_q   <= '0;
         hi_q    <= '0;
         first_q <= 1'b1;
         line_q  <= 1'b0;
      end else if (pulse_end_o) begin
         first_q <= 1'b0;
         cnt_q   <= '0;
         per_q   <= period_i;
         hi_q    <= hi_n;
         line_q  <= (hi_n != '0);
      end else begin
         cnt_q   <= cnt_inc;
         line_q  <= (cnt_inc < hi_q);
      end
   end

   // R1
   rise_on_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_q) |-> (cnt_q == '0));

   // R7
   cfg_held_mid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && (cnt_inc != per_q)) |=> ($stable(per_q) && $stable(hi_q)));
endmodule

// File: rtl/plm_slot_seq.sv
module plm_slot_seq
   import plm_pkg::*;
#(
   parameter bit GROUP_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_end_i,
   input  logic group_mode_i,
   input  logic bit_valid_i,
   input  logic bit_data_i,
   output logic bit_ready_o,
   output logic level_o,
   output logic group_start_o,
   output logic underrun_o
);
   slot_t slot_q;
   slot_t slot_n;
   logic  bit_q;
   logic  grp_q;
   logic  mode_sel;
   logic  last_slot;
   logic  new_bit;
   logic  gs_q;
   logic  ur_q;

   generate
      if (GROUP_EN) begin : g_grouped
         assign mode_sel  = group_mode_i;
         assign last_slot = !grp_q || (slot_q == slot_t'(GROUP_LEN - 1));
      end else begin : g_single
         assign mode_sel  = 1'b0;
         assign last_slot = 1'b1;
      end
   endgenerate

   assign bit_ready_o   = pulse_end_i & last_slot;
   assign new_bit       = bit_valid_i & bit_data_i;
   assign group_start_o = gs_q;
   assign underrun_o    = ur_q;

   always_comb begin
      slot_n  = slot_q + 1'b1;
      level_o = slot_level(slot_n, bit_q);
      if (bit_ready_o) begin
         slot_n  = '0;
         level_o = mode_sel ? 1'b1 : new_bit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= slot_t'(GROUP_LEN - 1);
         bit_q  <= 1'b0;
         grp_q  <= 1'b0;
         gs_q   <= 1'b0;
         ur_q   <= 1'b0;
      end else begin
         gs_q <= bit_ready_o;
         ur_q <= bit_ready_o & ~bit_valid_i;
         if (bit_ready_o) begin
            bit_q  <= new_bit;
            grp_q  <= mode_sel;
            slot_q <= '0;
         end else if (pulse_end_i) begin
            slot_q <= slot_n;
         end
      end
   end

   // R6
   underrun_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |-> group_start_o);

   // R5
   accept_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_ready_o |=> group_start_o);

   // R8
   mode_held_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_ready_o |=> $stable(grp_q));
endmodule

// File: rtl/plm_slot_tx.sv
module plm_slot_tx #(
   parameter int unsigned PERIOD_W = 8,
   parameter bit          GROUP_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period_i,
   input  logic [PERIOD_W-1:0] low_long_i,
   input  logic [PERIOD_W-1:0] low_short_i,
   input  logic                group_mode_i,
   input  logic                bit_valid_i,
   input  logic                bit_data_i,
   output logic                bit_ready_o,
   output logic                line_o,
   output logic                group_start_o,
   output logic                underrun_o
);
   logic pulse_end;
   logic level;

   generate
      if (PERIOD_W < 2) begin : g_bad_width
         $error("plm_slot_tx: PERIOD_W must be at least 2");
      end
   endgenerate

   plm_pulse_timer #(.PW(PERIOD_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .period_i    (period_i),
      .low_long_i  (low_long_i),
      .low_short_i (low_short_i),
      .level_i     (level),
      .pulse_end_o (pulse_end),
      .line_o      (line_o)
   );

   plm_slot_seq #(.GROUP_EN(GROUP_EN)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .pulse_end_i   (pulse_end),
      .group_mode_i  (group_mode_i),
      .bit_valid_i   (bit_valid_i),
      .bit_data_i    (bit_data_i),
      .bit_ready_o   (bit_ready_o),
      .level_o       (level),
      .group_start_o (group_start_o),
      .underrun_o    (underrun_o)
   );

   // R9
   start_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      group_start_o |-> $rose(line_o));

   // R9
   start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      group_start_o |=> !group_start_o);
endmodule

// File: tb/tb_plm_slot_tx.sv
`timescale 1ns/1ps
module tb_plm_slot_tx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_valid = 1'b0;
   logic bit_data = 1'b0;
   logic bit_ready, line, gstart, underrun;

   int cfg_per = 4, cfg_ll = 1, cfg_ls = 2, cfg_mode = 0;
   int pend_per, pend_ll, pend_ls, pend_mode;
   int checks = 0, fails = 0, cyc = 0;
   bit done = 1'b0;

   typedef struct {int hi; int per; int gs; int tag; int acc; int und;} exp_t;
   exp_t expq[$];

   always #4 clk = ~clk;   // 125 MHz

   plm_slot_tx dut (
      .clk(clk), .rst_n(rst_n),
      .period_i(8'(cfg_per)), .low_long_i(8'(cfg_ll)), .low_short_i(8'(cfg_ls)),
      .group_mode_i(cfg_mode[0]), .bit_valid_i(bit_valid), .bit_data_i(bit_data),
      .bit_ready_o(bit_ready), .line_o(line),
      .group_start_o(gstart), .underrun_o(underrun)
   );

   // mode, period, low_long, low_short, bit count, bits (sent MSB of count first)
   localparam logic [36:0] VEC [6] = '{
      {1'b0, 8'd4,  8'd1,  8'd2,  4'd8, 8'b10110010},
      {1'b0, 8'd5,  8'd2,  8'd3,  4'd6, 8'b00011010},
      {1'b1, 8'd4,  8'd1,  8'd2,  4'd3, 8'b00000101},
      {1'b0, 8'd32, 8'd8,  8'd24, 4'd4, 8'b00001001},
      {1'b1, 8'd5,  8'd2,  8'd3,  4'd2, 8'b00000001},
      {1'b0, 8'd3,  8'd1,  8'd2,  4'd3, 8'b00000110}
   };

   task automatic chk(input bit ok, input int tag, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, expv, cyc);
      end
   endtask

   function automatic int lvl(input int s, input int b);
      if (s == 0) return 1;
      if (s == 1) return 0;
      return (s % 2 == 1) ? b : 1 - b;
   endfunction

   // Expected pulses for one bit under the configuration driven now.
   function automatic void push_bit(input int b, input int tag, input int acc, input int und);
      int n = (cfg_mode != 0) ? 8 : 1;
      for (int s = 0; s < n; s++) begin
         exp_t e;
         int v = (cfg_mode != 0) ? lvl(s, b) : b;
         e.hi  = cfg_per - (v != 0 ? cfg_ll : cfg_ls);
         e.per = cfg_per;
         e.gs  = (s == 0);
         // R2 for ones, R3 for zeros, R4 inside groups unless overridden
         e.tag = (tag != 0) ? tag : ((cfg_mode != 0) ? 4 : (v != 0 ? 2 : 3));
         e.acc = acc;
         e.und = und;
         expq.push_back(e);
      end
   endfunction

   // Pulse monitor, sampling on falling edges.
   logic prev_line = 1'b0;
   int since = 0, hi_cnt = 0;
   bit have_cur = 1'b0;
   exp_t cur;
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         since++;
         if (line && !prev_line) begin
            if (have_cur) begin
               chk(since == cur.per, 1, "rise spacing", since, cur.per);     // R1
               chk(hi_cnt == cur.hi, cur.tag, "high time", hi_cnt, cur.hi);
            end
            if (expq.size() == 0) push_bit(0, 6, 0, 1);                      // R6 zero fill
            cur = expq.pop_front();
            have_cur = 1'b1;
            since = 0;
            hi_cnt = 1;
            chk(gstart == cur.gs[0], 9, "group_start at rise", gstart, cur.gs);  // R9
            chk(underrun == (cur.gs != 0 && cur.und != 0), 6, "underrun flag", underrun,
                cur.gs != 0 && cur.und != 0);                                // R6
            if (cur.gs != 0 && cur.und == 0)
               chk(cyc == cur.acc + 1, 5, "rise after accept", cyc, cur.acc + 1);   // R5
         end else begin
            if (line) hi_cnt++;
            if (gstart) chk(1'b0, 9, "group_start without rise", 1, 0);      // R9
         end
         prev_line = line;
      end
   end

   task automatic send_bit(input int b, input int tag, input bit use_pend);
      do @(negedge clk); while (!bit_ready);
      #1;
      if (use_pend) begin
         cfg_per = pend_per; cfg_ll = pend_ll; cfg_ls = pend_ls; cfg_mode = pend_mode;
      end
      bit_data = b[0];
      bit_valid = 1'b1;
      push_bit(b, tag, cyc, 0);
      @(posedge clk);
      #1 bit_valid = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R10: outputs low while reset is held
      repeat (3) @(negedge clk);
      chk(line == 1'b0, 10, "line in reset", line, 0);
      chk(gstart == 1'b0, 10, "group_start in reset", gstart, 0);
      chk(underrun == 1'b0, 10, "underrun in reset", underrun, 0);
      #1 rst_n = 1'b1;
      repeat (20) @(negedge clk);   // zero fill pulses, R6

      // Table walk: R1..R5, R9
      for (int v = 0; v < 6; v++) begin
         int n = int'(VEC[v][11:8]);
         pend_mode = int'(VEC[v][36]);
         pend_per  = int'(VEC[v][35:28]);
         pend_ll   = int'(VEC[v][27:20]);
         pend_ls   = int'(VEC[v][19:12]);
         for (int i = 0; i < n; i++)
            send_bit(int'(VEC[v][n - 1 - i]), 0, i == 0);
      end

      // R7: period and low times changed in the middle of a pulse
      pend_mode = 0; pend_per = 6; pend_ll = 2; pend_ls = 4;
      send_bit(1, 7, 1'b1);
      @(negedge clk); #1 cfg_per = 7; cfg_ll = 2; cfg_ls = 5;
      send_bit(0, 7, 1'b0);
      send_bit(1, 7, 1'b0);

      // R8: group mode dropped in the middle of a group
      pend_mode = 1; pend_per = 4; pend_ll = 1; pend_ls = 2;
      send_bit(0, 8, 1'b1);
      repeat (3) @(negedge clk);
      #1 cfg_mode = 0;
      send_bit(1, 0, 1'b0);
      send_bit(0, 0, 1'b0);

      // R6: gap in single mode, then a gap in group mode
      repeat (15) @(negedge clk);
      send_bit(1, 0, 1'b0);
      pend_mode = 1; pend_per = 4; pend_ll = 1; pend_ls = 2;
      send_bit(1, 0, 1'b1);
      repeat (80) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule